// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block sits on the host side of a 12-bit, 8-channel serial analog-to-digital converter. The converter is reached over a four-wire link: chip select, serial clock, command data toward the converter, and result data back from it. A fifth line carries the converter's strobe. When local logic raises a request, the sequencer selects the converter and shifts out an 8-bit command byte, most significant bit first. It then either keeps the serial clock running so that the converter completes its conversion on that clock, or it parks the clock and waits for the strobe to report that the converter's own oscillator has finished. In both cases it then clocks in the 12-bit result, most significant bit first, and hands it to local logic with a one-cycle valid pulse.

The serial clock comes from a divider of the system clock with equal high and low phases. The command byte is supplied whole at the request, so channel, polarity and mode fields stay the caller's business. The converter drives its data on falling serial-clock edges and samples on rising ones. The sequencer therefore changes its command output only on falling edges and samples result data only on rising edges. Two failure paths are covered. A missing strobe pulse in the self-clocked mode is flagged next to the result. A strobe that never reports completion in the converter-clocked mode ends the transaction after a programmable number of system cycles, and that case raises an error instead of a result.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After synchronous reset and whenever the block is idle, `cs_n_o` is 1, `sclk_o` is 0, `din_o` is 0, and `busy_o`, `valid_o` and `err_o` are 0.
- R2: `sclk_o` toggles only while `cs_n_o` is 0. Every high phase lasts exactly `HALF_DIV` system cycles. While the serial clock runs, every low phase, including the one from the fall of `cs_n_o` to the first rising edge, also lasts exactly `HALF_DIV` system cycles.
- R3: The converter sees the 8 bits of `cmd_i`, captured at the request, on rising serial-clock edges 1 to 8, bit 7 first. `din_o` changes only when `cs_n_o` falls or on a falling serial-clock edge, and it never changes while `sclk_o` is high.
- R4: With `ext_mode_i` = 1 at the request, the transaction has 24 serial clocks with no pause. Result bits 11 down to 0 are taken from `dout_i` on rising edges 10 to 21. `valid_o` pulses in the cycle that follows the last falling edge, and at that point `cs_n_o` is already 1 and `result_o` holds the word.
- R5: With `ext_mode_i` = 1, `strb_i` is sampled at rising edge 9. If it is 0 there, `err_o` pulses together with `valid_o`. Otherwise `err_o` stays 0.
- R6: With `ext_mode_i` = 0, the serial clock stops low after the 8 command clocks while `cs_n_o` stays 0. It restarts only once `strb_i` has been seen at 0 and then at 1. A further 16 clocks follow, with result bits 11 down to 0 taken on rising edges 2 to 13 of that readback run.
- R7: With `ext_mode_i` = 0, the wait for the strobe lasts at most `TMO_CYC` system cycles. A rise observed on cycle `TMO_CYC` of the wait still starts readback. If no rise comes by then, `cs_n_o` returns to 1, `err_o` pulses, `valid_o` stays 0 and `result_o` keeps its previous word.
- R8: `busy_o` is 1 from the cycle after an accepted request until the transaction ends. Requests seen while `busy_o` is 1 start nothing and change nothing. `valid_o` is a single-cycle pulse.
- R9: Values on `dout_i` outside the twelve result sampling edges, including all values while `cs_n_o` is 1, have no effect on `result_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Start a transaction (taken only when idle) |
| cmd_i | input | 8 | Command byte shifted to the converter |
| ext_mode_i | input | 1 | 1: converter runs on the serial clock; 0: converter uses its own clock and reports with the strobe |
| busy_o | output | 1 | Transaction in progress |
| valid_o | output | 1 | One-cycle pulse: `result_o` updated |
| err_o | output | 1 | One-cycle pulse: strobe missing or wait timed out |
| result_o | output | 12 | Last conversion result |
| cs_n_o | output | 1 | Converter select, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| din_o | output | 1 | Command data to the converter |
| dout_i | input | 1 | Result data from the converter |
| strb_i | input | 1 | Converter strobe |

## Verification
A wrong phase index inside the sequencer shows within one serial-clock half period. It appears as a high or low phase of the wrong length, a command bit that moves while the clock is high, or a captured command byte that differs from the one requested. A wrong capture window or shift order corrupts the returned word at the next valid pulse. A miscounted wait shows as a readback that starts before the strobe, a rise on the last allowed cycle that is treated as a timeout, or an error pulse with chip select still low. Each of these appears at the ports in the transaction where it happens, so every channel and mode combination is swept with a result word computed from its index, and the timeout boundary is tested on both sides.

// File: rtl/adc_seq_pkg.sv
// adc_seq_pkg: shared types for the serial ADC conversion sequencer.
// Assumes nothing beyond being compiled before the modules that import it.
package adc_seq_pkg;

    // Transaction phases of the sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // deselected, waiting for a request
        ST_CMD  = 2'd1,   // shifting the command byte
        ST_WAIT = 2'd2,   // clock parked, waiting for end-of-conversion strobe
        ST_READ = 2'd3    // clocking the result back
    } seq_state_t;

endpackage

// File: rtl/adc_seq_halfclk.sv
// adc_seq_halfclk: produces a one-cycle tick every HALF_DIV system clocks
// while 'run' is high; each tick marks one serial-clock half period.
// Assumes: the counter restarts from zero whenever 'run' is low, so the
// first tick after 'run' rises comes exactly HALF_DIV cycles later.
module adc_seq_halfclk #(
    parameter int unsigned HALF_DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    // Count system cycles within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/adc_seq_capture.sv
// adc_seq_capture: MSB-first serial-to-parallel result register.
// Assumes: 'clear' and 'shift' are never high together; 'sin' is stable
// in the cycle where 'shift' is high.
module adc_seq_capture #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    // Clear at transaction start, shift one bit in per sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            q <= '0;
        end else if (shift) begin
            q <= {q[W-2:0], sin};
        end
    end

endmodule

// File: rtl/adc_seq_strobe.sv
// adc_seq_strobe: watches the converter strobe during the parked-clock wait.
// Reports a low-to-high transition and a timeout after TMO_CYC cycles.
// Assumes: 'arm' pulses in the cycle that enters the wait; strb_i is
// synchronous to clk. A strobe already high at arm time does not count
// as a rise until it has been seen low.
module adc_seq_strobe #(
    parameter int unsigned TMO_CYC = 1200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic waiting,
    input  logic strb_i,
    output logic rise,
    output logic expired
);
    localparam int unsigned TW = $clog2(TMO_CYC + 1);
    localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);

    logic          prev_q;
    logic [TW-1:0] wcnt_q;

    // Remember the previous strobe level; pre-set high so a stuck-high line never rises.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= strb_i;
        end
    end

    // Count system cycles spent waiting, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            wcnt_q <= '0;
        end else if (waiting && !expired) begin
            wcnt_q <= wcnt_q + 1'b1;
        end
    end

    assign rise    = waiting && strb_i && !prev_q;
    assign expired = waiting && (wcnt_q == TMO_LAST);

endmodule

// File: rtl/adc_seq_ctrl.sv
// adc_seq_ctrl: host-side sequencer for a 12-bit serial ADC.
// On a request it selects the converter, shifts the command byte out
// MSB first, then either keeps clocking (ext_mode_i = 1, converter paced
// by the serial clock) or parks the clock until the strobe reports
// end of conversion (ext_mode_i = 0), and finally clocks the result in.
// Assumes: dout_i and strb_i are synchronous to clk (synchronised upstream);
// the converter drives dout_i after falling serial-clock edges and samples
// din_o on rising ones. RD_CLKS >= RD_LEAD + RES_W.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned HALF_DIV = 25,    // system cycles per serial-clock half period
    parameter int unsigned TMO_CYC  = 1200,  // maximum strobe wait in system cycles
    parameter int unsigned CMD_W    = 8,     // command byte width
    parameter int unsigned RES_W    = 12,    // result width
    parameter int unsigned RD_CLKS  = 16,    // serial clocks in the readback run
    parameter int unsigned RD_LEAD  = 1      // readback clocks before the MSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             ext_mode_i,
    output logic             busy_o,
    output logic             valid_o,
    output logic             err_o,
    output logic [RES_W-1:0] result_o,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             din_o,
    input  logic             dout_i,
    input  logic             strb_i
);
    localparam int unsigned CMD_HALVES = 2 * CMD_W;
    localparam int unsigned RD_HALVES  = 2 * RD_CLKS;
    localparam int unsigned MAX_HALVES = (RD_HALVES > CMD_HALVES) ? RD_HALVES : CMD_HALVES;
    localparam int unsigned HW         = $clog2(MAX_HALVES);
    localparam int unsigned EW         = HW - 1;
    localparam logic [HW-1:0] CMD_LAST_H = HW'(CMD_HALVES - 1);
    localparam logic [HW-1:0] RD_LAST_H  = HW'(RD_HALVES - 1);
    localparam logic [EW-1:0] CAP_FIRST  = EW'(RD_LEAD);
    localparam logic [EW-1:0] CAP_END    = EW'(RD_LEAD + RES_W);

    seq_state_t       state_q, state_d;
    logic [HW-1:0]    hcnt_q;
    logic [EW-1:0]    edge_idx;
    logic             sclk_q, cs_n_q, ext_q, strb_ok_q, valid_q, err_q;
    logic [CMD_W-1:0] cmd_sh_q;
    logic [RES_W-1:0] res_sh, result_q;
    logic             run, tick, rise_edge, fall_edge;
    logic             start, cmd_last, rd_last, capture, strb_chk;
    logic             arm, waiting, strb_rise, wait_expired, go_read, abort;

    assign run       = (state_q == ST_CMD) || (state_q == ST_READ);
    assign waiting   = (state_q == ST_WAIT);
    assign rise_edge = tick && !hcnt_q[0];
    assign fall_edge = tick &&  hcnt_q[0];
    assign edge_idx  = hcnt_q[HW-1:1];
    assign start     = (state_q == ST_IDLE) && req_i;
    assign cmd_last  = (state_q == ST_CMD)  && tick && (hcnt_q == CMD_LAST_H);
    assign rd_last   = (state_q == ST_READ) && tick && (hcnt_q == RD_LAST_H);
    assign capture   = (state_q == ST_READ) && rise_edge &&
                       (edge_idx >= CAP_FIRST) && (edge_idx < CAP_END);
    assign strb_chk  = (state_q == ST_READ) && ext_q && rise_edge && (edge_idx == '0);
    assign arm       = cmd_last && !ext_q;
    assign go_read   = waiting && strb_rise;
    assign abort     = waiting && !strb_rise && wait_expired;

    adc_seq_halfclk #(.HALF_DIV(HALF_DIV)) u_halfclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    adc_seq_strobe #(.TMO_CYC(TMO_CYC)) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .waiting (waiting),
        .strb_i  (strb_i),
        .rise    (strb_rise),
        .expired (wait_expired)
    );

    adc_seq_capture #(.W(RES_W)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .shift (capture),
        .sin   (dout_i),
        .q     (res_sh)
    );

    // Choose the next transaction phase.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (req_i)    state_d = ST_CMD;
            ST_CMD:  if (cmd_last) state_d = ext_q ? ST_READ : ST_WAIT;
            ST_WAIT: begin
                if (go_read)      state_d = ST_READ;
                else if (abort)   state_d = ST_IDLE;
            end
            ST_READ: if (rd_last)  state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // Hold the transaction phase.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Index the half period within the current clocked phase.
    always_ff @(posedge clk) begin
        if (!rst_n || start || go_read) begin
            hcnt_q <= '0;
        end else if (tick) begin
            hcnt_q <= (cmd_last || rd_last) ? '0 : hcnt_q + 1'b1;
        end
    end

    // Toggle the serial clock on every half-period tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    sclk_q <= 1'b0;
        else if (tick) sclk_q <= ~sclk_q;
    end

    // Select the converter for the length of a transaction.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cs_n_q <= 1'b1;
        else if (start)             cs_n_q <= 1'b0;
        else if (rd_last || abort)  cs_n_q <= 1'b1;
    end

    // Shift the command byte out, advancing only on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 cmd_sh_q <= '0;
        else if (start)                             cmd_sh_q <= cmd_i;
        else if ((state_q == ST_CMD) && fall_edge)  cmd_sh_q <= {cmd_sh_q[CMD_W-2:0], 1'b0};
    end

    // Latch the mode and the outcome of the strobe-pulse check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q     <= 1'b0;
            strb_ok_q <= 1'b0;
        end else if (start) begin
            ext_q     <= ext_mode_i;
            strb_ok_q <= 1'b0;
        end else if (strb_chk) begin
            strb_ok_q <= strb_i;
        end
    end

    // Publish the result and the completion and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            valid_q  <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (rd_last) result_q <= res_sh;
            valid_q <= rd_last;
            err_q   <= (rd_last && ext_q && !strb_ok_q) || abort;
        end
    end

    assign busy_o   = (state_q != ST_IDLE);
    assign valid_o  = valid_q;
    assign err_o    = err_q;
    assign result_o = result_q;
    assign cs_n_o   = cs_n_q;
    assign sclk_o   = sclk_q;
    assign din_o    = cmd_sh_q[CMD_W-1];

endmodule

// adc_seq_ctrl_chk: protocol properties observed at the sequencer's ports.
// Assumes: bound to every adc_seq_ctrl instance through the bind below.
module adc_seq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n_o,
    input logic sclk_o,
    input logic din_o,
    input logic busy_o,
    input logic valid_o,
    input logic err_o
);
    // R1: idle means deselected with the serial clock low.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && !sclk_o));

    // R2: the serial clock is never high while the converter is deselected.
    p_sclk_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R3: command data holds still across a high serial-clock phase.
    p_din_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(din_o));

    // R4: completion is reported only after deselecting.
    p_done_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cs_n_o && !busy_o));

    // R7: an error is reported only after deselecting.
    p_err_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> cs_n_o);

    // R8: the valid indication lasts exactly one cycle.
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8: a busy sequencer keeps the converter selected.
    p_busy_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !cs_n_o);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .din_o   (din_o),
    .busy_o  (busy_o),
    .valid_o (valid_o),
    .err_o   (err_o)
);

// File: tb/tb_adc_seq_ctrl.sv
// tb_adc_seq_ctrl: sweeps channels and modes of the sequencer against a
// behavioural converter model; expected words are computed arithmetically.
module tb_adc_seq_ctrl;
    localparam int HALF = 2;
    localparam int TMO  = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [7:0]  cmd_in = 8'h00;
    logic        ext_in = 1'b0;
    logic        busy_o, valid_o, err_o, cs_n_o, sclk_o, din_o;
    logic [11:0] result_o;
    logic        dout = 1'b1;
    logic        strb = 1'b1;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // Converter model state.
    logic [11:0] m_res = '0;
    bit          m_ext = 1'b0;
    bit          m_sen = 1'b1;
    int          m_dly = 10;
    int          rise_cnt = 0;
    int          fall_cnt = 0;
    logic [7:0]  cap_cmd = '0;
    bit          conv_pending = 1'b0;
    int          conv_cnt = 0;
    int          rises_at_strb = -1;

    // Port monitor state.
    int hi_bad = 0, lo_bad = 0, din_bad = 0, idle_bad = 0;
    int run_len = 0;
    logic sc_prev = 1'b0, dn_prev = 1'b0, dn_prev_sc = 1'b0;

    adc_seq_ctrl #(.HALF_DIV(HALF), .TMO_CYC(TMO)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .cmd_i      (cmd_in),
        .ext_mode_i (ext_in),
        .busy_o     (busy_o),
        .valid_o    (valid_o),
        .err_o      (err_o),
        .result_o   (result_o),
        .cs_n_o     (cs_n_o),
        .sclk_o     (sclk_o),
        .din_o      (din_o),
        .dout_i     (dout),
        .strb_i     (strb)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Watchdog: a hung run is one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp<=%0d", cyc, 100000);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    // Converter model: frame start.
    always @(negedge cs_n_o) begin
        rise_cnt = 0; fall_cnt = 0; cap_cmd = '0;
    end

    // Converter model: sample command bits on rising edges.
    always @(posedge sclk_o) begin
        if (!cs_n_o) begin
            rise_cnt++;
            if (rise_cnt <= 8) cap_cmd = {cap_cmd[6:0], din_o};
        end
    end

    // Converter model: drive data and strobe on falling edges; 1 outside the result window.
    always @(negedge sclk_o) begin
        if (!cs_n_o) begin
            fall_cnt++;
            dout = (fall_cnt >= 9 && fall_cnt <= 20) ? m_res[20 - fall_cnt] : 1'b1;
            if (fall_cnt == 8) begin
                if (m_ext) strb = m_sen;
                else begin strb = 1'b0; conv_pending = 1'b1; conv_cnt = 0; end
            end
            if (fall_cnt == 9 && m_ext) strb = 1'b0;
        end
    end

    // Converter model: self-clocked conversion time.
    always @(negedge clk) begin
        if (conv_pending) begin
            conv_cnt++;
            if (conv_cnt == m_dly) begin
                strb = 1'b1; conv_pending = 1'b0; rises_at_strb = rise_cnt;
            end
        end
    end

    // Port monitor: phase lengths, command stability, idle clock.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n_o) begin
                if (sclk_o) idle_bad++;
                run_len = 0; sc_prev = 1'b0;
            end else begin
                if (run_len == 0) begin sc_prev = sclk_o; run_len = 1; end
                else if (sclk_o == sc_prev) run_len++;
                else begin
                    if (sc_prev && run_len != HALF) hi_bad++;
                    if (!sc_prev && m_ext && run_len != HALF) lo_bad++;
                    sc_prev = sclk_o; run_len = 1;
                end
                if (sclk_o && dn_prev_sc && din_o != dn_prev) din_bad++;
            end
            dn_prev = din_o; dn_prev_sc = sclk_o;
        end
    end

    task automatic run_txn(input logic [7:0] cmd, input bit ext, input logic [11:0] res,
                           input bit sen, input int dly, input bit exp_tmo);
        logic [11:0] prev_res;
        int n;
        m_res = res; m_ext = ext; m_sen = sen; m_dly = dly;
        rises_at_strb = -1;
        if (!ext) strb = 1'b1;
        prev_res = result_o;
        @(negedge clk); req = 1'b1; cmd_in = cmd; ext_in = ext;
        @(negedge clk); req = 1'b0; cmd_in = ~cmd; ext_in = ~ext;
        chk(busy_o == 1'b1, "R8 busy after request", int'(busy_o), 1);
        n = 0;
        while (!(valid_o || err_o) && n < 2000) begin
            if (n == 3) req = 1'b1;     // request while busy must be ignored
            if (n == 4) req = 1'b0;
            @(negedge clk); n++;
        end
        chk(n < 2000, "R8 transaction ends", n, 2000);
        chk(cap_cmd == cmd, "R3 command bits seen by converter", int'(cap_cmd), int'(cmd));
        chk(cs_n_o == 1'b1 && busy_o == 1'b0, "R8 deselected at end", int'(cs_n_o), 1);
        if (exp_tmo) begin
            chk(err_o == 1'b1, "R7 timeout error", int'(err_o), 1);
            chk(valid_o == 1'b0, "R7 no valid on timeout", int'(valid_o), 0);
            chk(result_o == prev_res, "R7 result kept on timeout", int'(result_o), int'(prev_res));
            chk(rise_cnt == 8, "R6 clocks before timeout", rise_cnt, 8);
        end else begin
            chk(valid_o == 1'b1, "R4 valid pulse", int'(valid_o), 1);
            chk(result_o == res, "R4 R6 result word", int'(result_o), int'(res));
            chk(err_o == (ext && !sen), "R5 strobe error flag", int'(err_o), int'(ext && !sen));
            chk(rise_cnt == 24, "R4 R6 serial clocks per frame", rise_cnt, 24);
            if (!ext) chk(rises_at_strb == 8, "R6 clock parked during conversion", rises_at_strb, 8);
        end
        @(negedge clk);
        chk(valid_o == 1'b0 && err_o == 1'b0, "R8 single-cycle pulses", int'(valid_o | err_o), 0);
        chk(busy_o == 1'b0 && cs_n_o == 1'b1, "R8 ignored request started nothing", int'(busy_o), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(cs_n_o == 1'b1, "R1 cs_n in reset", int'(cs_n_o), 1);
        chk(sclk_o == 1'b0, "R1 sclk in reset", int'(sclk_o), 0);
        chk(din_o == 1'b0, "R1 din in reset", int'(din_o), 0);
        chk(busy_o == 1'b0, "R1 busy in reset", int'(busy_o), 0);
        chk(valid_o == 1'b0 && err_o == 1'b0, "R1 pulses in reset", int'(valid_o | err_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n_o == 1'b1 && busy_o == 1'b0, "R1 idle after reset", int'(busy_o), 0);

        // Sweep all channels in both modes; the word is derived from the index.
        for (int ch = 0; ch < 8; ch++) begin
            for (int e = 0; e < 2; e++) begin
                logic [7:0]  c;
                logic [11:0] r;
                c = {1'b1, 3'(ch), 1'b1, 1'b0, 1'(e), 1'b1};
                r = 12'((ch * 1237 + e * 611 + 5) % 4096);
                run_txn(c, e[0], r, 1'b1, 10, 1'b0);
            end
        end

        // Boundary words, where R9 is covered by the model's 1s outside the window.
        run_txn(8'hFF, 1'b1, 12'hFFF, 1'b1, 10, 1'b0);
        run_txn(8'h80, 1'b0, 12'h000, 1'b1, 10, 1'b0);
        run_txn(8'hA5, 1'b1, 12'h800, 1'b1, 10, 1'b0);
        run_txn(8'h5A, 1'b0, 12'h001, 1'b1, 2, 1'b0);

        // R5: missing strobe pulse in the serially clocked mode.
        run_txn(8'hC3, 1'b1, 12'h5A5, 1'b0, 10, 1'b0);
        // R7: rise on the last allowed cycle, then one cycle too late.
        run_txn(8'h96, 1'b0, 12'h3C3, 1'b1, TMO, 1'b0);
        run_txn(8'h69, 1'b0, 12'h7E7, 1'b1, TMO + 1, 1'b1);
        // Recovery after a timeout.
        run_txn(8'hB1, 1'b0, 12'hABC, 1'b1, 7, 1'b0);

        // R2 and R3: port monitor totals.
        chk(hi_bad == 0, "R2 high phase length", hi_bad, 0);
        chk(lo_bad == 0, "R2 low phase length", lo_bad, 0);
        chk(idle_bad == 0, "R2 sclk while deselected", idle_bad, 0);
        chk(din_bad == 0, "R3 din moved while sclk high", din_bad, 0);

        summary();
        $finish;
    end

endmodule